// File: doc/BRIEF.md
# DDR SDRAM Bank State Tracker

This block watches the decoded command stream of a four-bank double-data-rate SDRAM interface and keeps a live picture of each bank: idle, or active with a known open row. It also times the burst that follows each accepted READ or WRITE. When auto-precharge is requested, it closes the bank by itself when that burst ends.

Commands that break the bank protocol are not applied. Instead they set sticky error flags, and a 3-bit code holds the first violation seen until software pulses the clear input. The tracker is meant to sit beside a memory controller or a bus monitor as a protocol watchdog. It is also a source of open-row information for page-hit decisions.

Top module: `ddr_bank_tracker`

## Requirements
- R1: After reset all banks are idle, every open-row register and `col_o` read zero, `burst_o` is low, and the error flags and code are zero.
- R2: Command encoding on `cmd_i` is 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 AUTO REFRESH, 6 MODE REGISTER SET, 7 treated as NOP. An ACTIVE to an idle bank selected by `ba_i` makes that bank active one cycle later. Its row register (bits `ba*14 +: 14` of `open_row_o`) then holds `addr_i[13:0]`.
- R3: An ACTIVE to a bank that is already active leaves the bank and its row unchanged. It sets flag bit 0 and, if no code is held, code 1.
- R4: A READ or WRITE to an idle bank starts no burst and does not update `col_o`. It sets flag bit 1 and, if no code is held, code 2.
- R5: A READ or WRITE to an active bank raises `burst_o` from the next cycle for BL/2 cycles. `bl_i` selects this: 2 gives BL4 (2 cycles), 3 gives BL8 (4 cycles), and 1 or 0 give BL2 (1 cycle). `col_o` becomes {A12, A11, A9..A0}.
- R6: With `addr_i[10]` high on an accepted READ or WRITE, the bank goes idle at the same edge where `burst_o` falls. A new accepted READ or WRITE during a burst restarts the burst. A pending auto-precharge for a different bank closes that bank at that edge; for the same bank, the new command's A10 replaces it.
- R7: A PRECHARGE with `addr_i[10]` low closes only the bank on `ba_i`. With A10 high it closes every bank regardless of `ba_i`. A PRECHARGE that closes a bank with a pending auto-precharge cancels that pending close.
- R8: A MODE REGISTER SET while any bank is active or `burst_o` is high sets flag bit 2 and, if no code is held, code 3.
- R9: An AUTO REFRESH while any bank is active sets flag bit 3 and, if no code is held, code 4. With all banks idle it has no effect.
- R10: While `cke_i` is low, commands are ignored. A running burst still counts down and may still auto-close its bank.
- R11: Error flags stay set until `err_clr_i` is high for a cycle. The code keeps the first violation after reset or after a clear. A violation in the same cycle as a clear is recorded after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; commands are checked only when high |
| cmd_i | input | 3 | Decoded command code |
| ba_i | input | 2 | Bank address |
| addr_i | input | 14 | Row or column address; bit 10 selects precharge scope or auto-precharge |
| bl_i | input | 2 | Configured burst length selector |
| err_clr_i | input | 1 | Clears sticky error flags and code |
| bank_active_o | output | 4 | Per-bank active state |
| open_row_o | output | 56 | Open row of each bank, 14 bits per bank, bank 0 in the low bits |
| burst_o | output | 1 | Burst in progress |
| col_o | output | 12 | Column of the last accepted READ or WRITE |
| err_flags_o | output | 4 | Sticky violation flags |
| err_code_o | output | 3 | Code of the first violation, 0 when none |

## Verification
Every output is a register. The effect of a command sampled at an edge therefore shows up in the cycle right after that edge, and `burst_o` then stays high for exactly BL/2 cycles. An auto-precharge close shows on `bank_active_o` in the same cycle where `burst_o` has just fallen. The bench keeps a behavioural model that advances on the same edge, and compares all six outputs with it at every falling clock edge. The comparisons therefore always observe the settled post-edge state. Directed sequences set up bursts that are truncated, cancelled by precharge and overlapped with mode register loads. A random phase then mixes every command with CKE drops and clears.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6,
    CMD_RSV = 3'd7
  } cmd_e;

  localparam int NUM_ERR  = 4;
  localparam int CODE_W   = 3;
  localparam int ERR_ACT  = 0;
  localparam int ERR_RW   = 1;
  localparam int ERR_MRS  = 2;
  localparam int ERR_REF  = 3;
endpackage

// File: rtl/ddr_trk_bank.sv
module ddr_trk_bank #(
  parameter int ROW_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             active_o,
  output logic [ROW_W-1:0] row_o
);
  logic             act_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      row_q <= '0;
    end else if (open_i) begin
      act_q <= 1'b1;
      row_q <= row_i;
    end else if (close_i) begin
      act_q <= 1'b0;
    end
  end

  assign active_o = act_q;
  assign row_o    = row_q;

  AST_OPEN_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_i |=> active_o && (row_o == $past(row_i)));  // R2
  AST_CLOSE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_i && !open_i) |=> !active_o);  // R7
endmodule

// File: rtl/ddr_trk_burst.sv
module ddr_trk_burst #(
  parameter int CNT_W = 4,
  parameter int BA_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             ap_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic             pre_all_i,
  input  logic             pre_one_i,
  input  logic [BA_W-1:0]  pre_bank_i,
  output logic             busy_o,
  output logic             ap_close_o,
  output logic [BA_W-1:0]  ap_bank_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ap_q;
  logic [BA_W-1:0]  apb_q;
  logic             last;
  logic             pre_hit;

  assign busy_o  = (cnt_q != '0);
  assign last    = (cnt_q == CNT_W'(1));
  assign pre_hit = pre_all_i || (pre_one_i && (pre_bank_i == apb_q));

  // close at natural end, or when a new burst to another bank truncates this one
  assign ap_close_o = ap_q && busy_o &&
                      ((last && !start_i) || (start_i && (bank_i != apb_q)));
  assign ap_bank_o  = apb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ap_q  <= 1'b0;
      apb_q <= '0;
    end else if (start_i) begin
      cnt_q <= len_i;
      ap_q  <= ap_i;
      apb_q <= bank_i;
    end else begin
      if (busy_o) cnt_q <= cnt_q - CNT_W'(1);
      if (pre_hit || last) ap_q <= 1'b0;
    end
  end

  AST_BURST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && len_i != '0) |=> busy_o);  // R5
  AST_AP_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ap_close_o && !start_i) |=> !busy_o);  // R6
endmodule

// File: rtl/ddr_trk_err.sv
module ddr_trk_err #(
  parameter int NUM_ERR = 4,
  parameter int CODE_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ERR-1:0] viol_i,
  input  logic               clr_i,
  output logic [NUM_ERR-1:0] flags_o,
  output logic [CODE_W-1:0]  code_o
);
  logic [NUM_ERR-1:0] flags_q;
  logic [CODE_W-1:0]  code_q;
  logic [CODE_W-1:0]  viol_code;

  always_comb begin
    viol_code = '0;
    for (int i = NUM_ERR - 1; i >= 0; i--)
      if (viol_i[i]) viol_code = CODE_W'(i + 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      code_q  <= '0;
    end else begin
      flags_q <= (clr_i ? '0 : flags_q) | viol_i;
      if (clr_i || code_q == '0) code_q <= viol_code;
    end
  end

  assign flags_o = flags_q;
  assign code_o  = code_q;

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (($past(flags_q) & ~flags_q) == '0));  // R11
  AST_FIRST_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && code_q != '0) |=> $stable(code_q));  // R11
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
  import ddr_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 14,
  parameter int CNT_W     = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cke_i,
  input  logic [2:0]                 cmd_i,
  input  logic [1:0]                 ba_i,
  input  logic [13:0]                addr_i,
  input  logic [1:0]                 bl_i,
  input  logic                       err_clr_i,
  output logic [NUM_BANKS-1:0]       bank_active_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
  output logic                       burst_o,
  output logic [11:0]                col_o,
  output logic [NUM_ERR-1:0]         err_flags_o,
  output logic [CODE_W-1:0]          err_code_o
);
  localparam int BA_W   = $clog2(NUM_BANKS);
  localparam int AP_BIT = 10;
  localparam int COL_W  = 12;

  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] sel_oh;
  logic [NUM_BANKS-1:0] act_q;
  logic                 is_act, is_rw, is_pre, is_ref, is_mrs;
  logic                 tgt_open, any_open;
  logic                 act_ok, rw_ok;
  logic                 pre_all, pre_one;
  logic [CNT_W-1:0]     burst_len;
  logic                 busy, ap_close;
  logic [BA_W-1:0]      ap_bank;
  logic [NUM_ERR-1:0]   viol;
  logic [COL_W-1:0]     col_q;

  assign cmd    = cmd_e'(cmd_i);
  assign is_act = cke_i && (cmd == CMD_ACT);
  assign is_rw  = cke_i && (cmd == CMD_RD || cmd == CMD_WR);
  assign is_pre = cke_i && (cmd == CMD_PRE);
  assign is_ref = cke_i && (cmd == CMD_REF);
  assign is_mrs = cke_i && (cmd == CMD_MRS);

  assign tgt_open = |(act_q & sel_oh);
  assign any_open = |act_q;
  assign act_ok   = is_act && !tgt_open;
  assign rw_ok    = is_rw && tgt_open;
  assign pre_all  = is_pre && addr_i[AP_BIT];
  assign pre_one  = is_pre && !addr_i[AP_BIT];

  always_comb begin
    viol          = '0;
    viol[ERR_ACT] = is_act && tgt_open;
    viol[ERR_RW]  = is_rw && !tgt_open;
    viol[ERR_MRS] = is_mrs && (any_open || busy);
    viol[ERR_REF] = is_ref && any_open;
  end

  // two transfers per clock: cycles = BL/2
  always_comb begin
    unique case (bl_i)
      2'd2:    burst_len = CNT_W'(2);
      2'd3:    burst_len = CNT_W'(4);
      default: burst_len = CNT_W'(1);
    endcase
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic close_g;
    assign sel_oh[g] = (ba_i == BA_W'(g));
    assign close_g   = pre_all || (pre_one && sel_oh[g]) ||
                       (ap_close && (ap_bank == BA_W'(g)));
    ddr_trk_bank #(.ROW_W(ROW_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .open_i   (act_ok && sel_oh[g]),
      .close_i  (close_g),
      .row_i    (addr_i[ROW_W-1:0]),
      .active_o (act_q[g]),
      .row_o    (open_row_o[g*ROW_W +: ROW_W])
    );
  end

  ddr_trk_burst #(.CNT_W(CNT_W), .BA_W(BA_W)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (rw_ok),
    .len_i      (burst_len),
    .ap_i       (addr_i[AP_BIT]),
    .bank_i     (ba_i),
    .pre_all_i  (pre_all),
    .pre_one_i  (pre_one),
    .pre_bank_i (ba_i),
    .busy_o     (busy),
    .ap_close_o (ap_close),
    .ap_bank_o  (ap_bank)
  );

  ddr_trk_err #(.NUM_ERR(NUM_ERR), .CODE_W(CODE_W)) u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .viol_i  (viol),
    .clr_i   (err_clr_i),
    .flags_o (err_flags_o),
    .code_o  (err_code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) col_q <= '0;
    else if (rw_ok) col_q <= {addr_i[12], addr_i[11], addr_i[9:0]};
  end

  assign bank_active_o = act_q;
  assign burst_o       = busy;
  assign col_o         = col_q;

  AST_ACT_TWICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act && bank_active_o[ba_i]) |=> err_flags_o[ERR_ACT]);  // R3
  AST_RW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rw && !bank_active_o[ba_i]) |=> err_flags_o[ERR_RW] && $stable(col_o));  // R4
  AST_MRS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mrs && (|bank_active_o || burst_o)) |=> err_flags_o[ERR_MRS]);  // R8
  AST_REF_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ref && |bank_active_o) |=> err_flags_o[ERR_REF]);  // R9
  AST_CKE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_i && !burst_o) |=> $stable(bank_active_o) && $stable(open_row_o));  // R10
endmodule

// File: tb/sim_ddr_bank_tracker.sv
`timescale 1ns/1ps
module sim_ddr_bank_tracker;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cke = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  ba = 2'd0;
  logic [13:0] addr = 14'd0;
  logic [1:0]  bl = 2'd1;
  logic        clr = 1'b0;

  logic [3:0]  bank_active;
  logic [55:0] open_row;
  logic        burst;
  logic [11:0] col;
  logic [3:0]  err_flags;
  logic [2:0]  err_code;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  ddr_bank_tracker u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cmd_i(cmd), .ba_i(ba),
    .addr_i(addr), .bl_i(bl), .err_clr_i(clr),
    .bank_active_o(bank_active), .open_row_o(open_row), .burst_o(burst),
    .col_o(col), .err_flags_o(err_flags), .err_code_o(err_code)
  );

  // behavioural reference
  bit [3:0]  m_act;
  bit [13:0] m_row [4];
  int        m_cnt;
  bit        m_ap;
  int        m_apb;
  bit [11:0] m_col;
  bit [3:0]  m_flags;
  int        m_code;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_act = 0; m_cnt = 0; m_ap = 0; m_apb = 0; m_col = 0; m_flags = 0; m_code = 0;
      foreach (m_row[i]) m_row[i] = 0;
    end else begin
      int b, viol, ap_victim, len;
      bit start;
      b = ba; viol = 0; ap_victim = -1;
      len = (bl == 2'd3) ? 4 : (bl == 2'd2) ? 2 : 1;
      start = cke && (cmd == 3'd2 || cmd == 3'd3) && m_act[b];
      if (m_cnt > 0 && m_ap && ((m_cnt == 1 && !start) || (start && b != m_apb)))
        ap_victim = m_apb;
      if (cke) begin
        case (cmd)
          3'd1: if (m_act[b]) viol = 1; else begin m_act[b] = 1; m_row[b] = addr; end
          3'd2, 3'd3: if (!m_act[b]) viol = 2; else m_col = {addr[12], addr[11], addr[9:0]};
          3'd4: if (addr[10]) begin m_act = 0; m_ap = 0; end
                else begin m_act[b] = 0; if (b == m_apb) m_ap = 0; end
          3'd5: if (m_act != 0) viol = 4;
          3'd6: if (m_act != 0 || m_cnt > 0) viol = 3;
          default: ;
        endcase
      end
      if (ap_victim >= 0) m_act[ap_victim] = 0;
      if (start) begin
        m_cnt = len; m_ap = addr[10]; m_apb = b;
      end else begin
        if (m_cnt > 0) m_cnt--;
        if (m_cnt == 0) m_ap = 0;
      end
      if (clr) begin m_flags = 0; m_code = 0; end
      if (viol != 0) begin
        m_flags[viol-1] = 1;
        if (m_code == 0) m_code = viol;
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [55:0] rows;
    for (int i = 0; i < 4; i++) rows[i*14 +: 14] = m_row[i];
    chk("bank_active", 64'(bank_active), 64'(m_act));
    chk("open_row", 64'(open_row), 64'(rows));
    chk("burst", 64'(burst), 64'(m_cnt > 0));
    chk("col", 64'(col), 64'(m_col));
    chk("err_flags", 64'(err_flags), 64'(m_flags));
    chk("err_code", 64'(err_code), 64'(m_code));
  end

  task automatic cyc(input logic [2:0] c, input logic [1:0] b, input logic [13:0] a);
    @(negedge clk);
    cmd = c; ba = b; addr = a; clr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(3'd0, 2'd0, 14'd0);
  endtask

  task automatic clear();
    @(negedge clk);
    cmd = 3'd0; clr = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state checked explicitly
    chk("reset_active", 64'(bank_active), 64'd0);
    chk("reset_flags", 64'({burst, err_flags, err_code}), 64'd0);
    rst_ni = 1'b1;

    cur_req = "R2";  // open two banks, extreme rows
    cyc(3'd1, 2'd0, 14'h1234);
    cyc(3'd1, 2'd3, 14'h3FFF);
    idle(2);

    cur_req = "R3";  // second ACTIVE to open bank
    cyc(3'd1, 2'd0, 14'h0555);
    idle(2);
    clear(); idle(1);

    cur_req = "R4";  // read to idle bank
    cyc(3'd2, 2'd2, 14'h0ABC);
    idle(2);
    clear(); idle(1);

    cur_req = "R5";  // three burst lengths, column bit mapping
    bl = 2'd1; cyc(3'd2, 2'd0, 14'h1BFF); idle(3);
    bl = 2'd2; cyc(3'd3, 2'd3, 14'h1801); idle(4);
    bl = 2'd3; cyc(3'd2, 2'd0, 14'h0A5A & ~14'h0400); idle(6);
    bl = 2'd0; cyc(3'd3, 2'd0, 14'h0003); idle(2);

    cur_req = "R6";  // auto-precharge at end, then truncation by other bank
    bl = 2'd3;
    cyc(3'd2, 2'd3, 14'h0400 | 14'h0010); idle(6);
    cyc(3'd1, 2'd3, 14'h0777);
    cyc(3'd2, 2'd0, 14'h0400); idle(1);
    bl = 2'd2; cyc(3'd3, 2'd3, 14'h0020); idle(4);
    cyc(3'd1, 2'd0, 14'h0042);
    bl = 2'd3; cyc(3'd2, 2'd0, 14'h0400); cyc(3'd3, 2'd0, 14'h0001); idle(6);

    cur_req = "R7";  // single, cancelling and all-bank precharge
    cyc(3'd1, 2'd1, 14'h0101); cyc(3'd1, 2'd2, 14'h0202);
    cyc(3'd4, 2'd1, 14'h0000); idle(1);
    cyc(3'd2, 2'd2, 14'h0400); cyc(3'd4, 2'd2, 14'h0000);
    cyc(3'd1, 2'd2, 14'h0303); idle(5);
    cyc(3'd4, 2'd1, 14'h0400); idle(2);

    cur_req = "R8";  // MRS with open bank, then during burst only
    cyc(3'd1, 2'd0, 14'h0011); cyc(3'd6, 2'd0, 14'h0022); idle(1);
    clear();
    cyc(3'd2, 2'd0, 14'h0400); cyc(3'd6, 2'd0, 14'h0000); idle(6);
    cyc(3'd6, 2'd0, 14'h0000); idle(1);
    clear(); idle(1);

    cur_req = "R9";  // refresh with bank open, then idle refresh
    cyc(3'd1, 2'd1, 14'h0099); cyc(3'd5, 2'd0, 14'h0000); idle(1);
    cyc(3'd4, 2'd0, 14'h0400); cyc(3'd5, 2'd0, 14'h0000); idle(1);

    cur_req = "R10";  // CKE low ignores ACT and bad MRS; burst still ends
    cyc(3'd1, 2'd2, 14'h0123);
    cyc(3'd2, 2'd2, 14'h0400);
    cke = 1'b0;
    cyc(3'd1, 2'd1, 14'h0456); cyc(3'd6, 2'd0, 14'h0000); idle(5);
    cke = 1'b1; idle(1);

    cur_req = "R11";  // first code kept, clear with simultaneous violation
    cyc(3'd5, 2'd0, 14'h0000);
    cyc(3'd1, 2'd1, 14'h0001); cyc(3'd1, 2'd1, 14'h0002);
    idle(1);
    @(negedge clk); cmd = 3'd2; ba = 2'd3; addr = 14'd0; clr = 1'b1;
    idle(2);
    clear(); idle(2);

    cur_req = "R5";  // random mix against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      cmd  = 3'($urandom_range(0, 7));
      ba   = 2'($urandom_range(0, 3));
      addr = 14'($urandom);
      bl   = 2'($urandom_range(0, 3));
      cke  = ($urandom_range(0, 9) != 0);
      clr  = ($urandom_range(0, 19) == 0);
    end
    idle(8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule